// File: doc/BRIEF.md
# Serial display command/data transmitter

This block turns a host byte stream into the four-wire, clock-synchronous serial link used by many small display controllers. The link has an active-low chip select, a register-select line, a serial clock and a serial data line. The block marks each transaction with a flag. A command transaction carries a single byte with register-select low, which addresses the instruction register. A data transaction carries one or more bytes back to back with register-select high, which addresses the data register. Chip select stays low for the whole transaction.

The host presents bytes on a valid/ready stream. A byte is taken on a clock edge where both `in_valid` and `in_ready` are high. While `in_valid` is high and `in_ready` is low, the host must hold `in_data`, `in_is_data` and `in_last` steady. `in_ready` is high only when the link is idle, or when a data burst has finished the eighth rising clock edge of a byte and waits for the next one. A stalled burst holds the serial clock high with chip select low. The link does not time out.

The serial clock rate comes from `half_period`, the number of system clocks in each clock phase. The block samples it when a transaction starts.

Top module: `serdisp_tx`

## Requirements
- R1: After reset, and whenever no transaction is running, `disp_csn`, `disp_rs`, `disp_sck` and `disp_sda` are all high, `busy` is low and `in_ready` is high.
- R2: A byte accepted from idle with `in_is_data`=0 is a command. It sends exactly one byte with `disp_rs` low, and the link returns to idle after that byte even when `in_last` is 0.
- R3: A byte accepted from idle with `in_is_data`=1 opens a data burst with `disp_rs` high. The burst accepts further bytes until a byte with `in_last`=1 has been sent, and `disp_csn` stays low without a break across all of its bytes.
- R4: Each byte goes out most significant bit first, as exactly 8 rising edges of `disp_sck`. `disp_sda` changes only while `disp_sck` is low, so it never changes on the cycle in which `disp_sck` rises.
- R5: On the clock after a byte is accepted from idle, `disp_csn` and `disp_sck` are low and `disp_sda` is high. This setup phase lasts one phase length before the first bit is driven.
- R6: Every setup, clock-low and clock-high phase lasts H system clocks. H is the value of `half_period`, and a value of 0 counts as 1. H is captured when the byte is accepted from idle and ignored afterwards. A single-byte transaction therefore keeps `busy` high for 17*H clocks.
- R7: `in_ready` is low while a byte is being shifted out. Between burst bytes it is high, with `disp_sck` high and `disp_csn` low, for as long as no byte arrives.
- R8: When the final clock-high phase of a transaction ends, all four link lines go high on the next clock and `busy` falls.
- R9: `busy` is high from the clock on which `disp_csn` falls until the clock on which it rises.
- R10: Within a burst, `in_is_data` on the second and later bytes is ignored: `disp_rs` stays high at every eighth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | BYTE_W | Byte to send, MSB first |
| in_is_data | input | 1 | 1 = data (register-select high), 0 = command; used on the first byte only |
| in_last | input | 1 | Final byte of a data burst |
| half_period | input | DIV_W | System clocks per serial clock phase (0 treated as 1) |
| disp_csn | output | 1 | Chip select, active low |
| disp_rs | output | 1 | Register select: 0 instruction, 1 data |
| disp_sck | output | 1 | Serial clock, idles high |
| disp_sda | output | 1 | Serial data, idles high |
| busy | output | 1 | Transaction in progress |

## Verification
Two events can meet on one edge: the end of a transaction's final clock-high phase and a request for the next transaction that is already waiting. The bench provokes this by raising `in_valid` for a new command while the previous transaction is still shifting. It then judges the result by counting chip-select rising edges, by checking that both bytes appear in order on the serial data line, and by checking that the idle state separates them. A burst byte that arrives after a long stall in the wait state is checked in the same way. That byte must start its clock-low phase directly, with no second setup phase and no break in chip select.

// File: rtl/serdisp_pkg.sv
package serdisp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } link_state_t;

endpackage

// File: rtl/serdisp_phase_timer.sv
module serdisp_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             expired
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/serdisp_shifter.sv
module serdisp_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  output logic              cur_bit,
  output logic              next_bit,
  output logic              at_last
);

  localparam int IDX_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= din;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_bit  = sh_q[BYTE_W-1];
  assign next_bit = sh_q[BYTE_W-2];
  assign at_last  = (idx_q == IDX_W'(BYTE_W - 1));

endmodule

// File: rtl/serdisp_tx.sv
module serdisp_tx
  import serdisp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_is_data,
  input  logic              in_last,
  input  logic [DIV_W-1:0]  half_period,
  output logic              disp_csn,
  output logic              disp_rs,
  output logic              disp_sck,
  output logic              disp_sda,
  output logic              busy
);

  link_state_t st_q, st_nxt;

  logic [DIV_W-1:0] half_q, half_in_eff;
  logic             fin_q, fin_nxt;
  logic             csn_q, rs_q, sck_q, sda_q;
  logic             rs_nxt, sda_nxt;
  logic             accept;

  logic             tmr_load, tmr_expired;
  logic [DIV_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_cur, sh_next, sh_at_last;

  serdisp_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  serdisp_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sh_load),
    .shift    (sh_shift),
    .din      (in_data),
    .cur_bit  (sh_cur),
    .next_bit (sh_next),
    .at_last  (sh_at_last)
  );

  // Host handshake: open only when idle or parked between burst bytes.
  always_comb begin
    in_ready    = (st_q == ST_IDLE) || (st_q == ST_WAIT);
    accept      = in_valid && in_ready;
    half_in_eff = (half_period == '0) ? DIV_W'(1) : half_period;
  end

  // Next-state and next-line logic.
  always_comb begin
    st_nxt   = st_q;
    tmr_load = 1'b0;
    tmr_val  = half_q - DIV_W'(1);
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    fin_nxt  = fin_q;
    rs_nxt   = rs_q;
    sda_nxt  = sda_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_nxt   = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = half_in_eff - DIV_W'(1);
          sh_load  = 1'b1;
          fin_nxt  = !in_is_data || in_last;
          rs_nxt   = in_is_data;
          sda_nxt  = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tmr_expired) begin
          st_nxt   = ST_LOW;
          tmr_load = 1'b1;
          sda_nxt  = sh_cur;
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          st_nxt   = ST_HIGH;
          tmr_load = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_expired) begin
          if (sh_at_last) begin
            if (fin_q) begin
              st_nxt  = ST_IDLE;
              rs_nxt  = 1'b1;
              sda_nxt = 1'b1;
            end else begin
              st_nxt  = ST_WAIT;
            end
          end else begin
            st_nxt   = ST_LOW;
            tmr_load = 1'b1;
            sh_shift = 1'b1;
            sda_nxt  = sh_next;
          end
        end
      end
      ST_WAIT: begin
        if (accept) begin
          st_nxt   = ST_LOW;
          tmr_load = 1'b1;
          sh_load  = 1'b1;
          fin_nxt  = in_last;
          sda_nxt  = in_data[BYTE_W-1];
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= DIV_W'(1);
      fin_q  <= 1'b1;
      csn_q  <= 1'b1;
      rs_q   <= 1'b1;
      sck_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q  <= st_nxt;
      fin_q <= fin_nxt;
      rs_q  <= rs_nxt;
      sda_q <= sda_nxt;
      csn_q <= (st_nxt == ST_IDLE);
      sck_q <= (st_nxt == ST_IDLE) || (st_nxt == ST_HIGH) || (st_nxt == ST_WAIT);
      if (accept && (st_q == ST_IDLE)) half_q <= half_in_eff;
    end
  end

  assign disp_csn = csn_q;
  assign disp_rs  = rs_q;
  assign disp_sck = sck_q;
  assign disp_sda = sda_q;
  assign busy     = (st_q != ST_IDLE);

endmodule

// File: rtl/serdisp_tx_chk.sv
module serdisp_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic disp_csn,
  input logic disp_rs,
  input logic disp_sck,
  input logic disp_sda,
  input logic busy
);

  // R4
  sda_stable_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_sck) |-> $stable(disp_sda));

  // R7
  ready_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !disp_csn) |-> disp_sck);

  // R1
  idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (disp_csn && disp_rs && disp_sck && disp_sda));

  // R3
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_csn && !$past(disp_csn)) |-> $stable(disp_rs));

  // R5
  start_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_csn) |-> (!disp_sck && disp_sda));

  // R8
  end_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_csn) |-> $past(disp_sck));

endmodule

bind serdisp_tx serdisp_tx_chk u_chk (.*);

// File: tb/serdisp_tx_bench.sv
module serdisp_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_is_data = 1'b0;
  logic       in_last = 1'b0;
  logic [7:0] half_period = 8'd1;
  logic       disp_csn, disp_rs, disp_sck, disp_sda, busy;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  serdisp_tx u_serdisp_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_data(in_is_data), .in_last(in_last),
    .half_period(half_period), .disp_csn(disp_csn), .disp_rs(disp_rs),
    .disp_sck(disp_sck), .disp_sda(disp_sda), .busy(busy)
  );

  // Line monitor: cumulative counters, sampled on falling clock edges.
  logic [31:0] cap = '0;
  int rises = 0, rs0_at8 = 0, rs1_at8 = 0, unstable = 0, busy_cyc = 0, csn_rises = 0;
  logic p_sck = 1'b1, p_sda = 1'b1, p_csn = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (disp_sck && !p_sck && !disp_csn) begin
        rises++;
        cap = {cap[30:0], disp_sda};
        if (disp_sda != p_sda) unstable++;
        if (rises % 8 == 0) begin
          if (disp_rs) rs1_at8++; else rs0_at8++;
        end
      end
      if (disp_csn && !p_csn) csn_rises++;
      p_sck = disp_sck;
      p_sda = disp_sda;
      p_csn = disp_csn;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit isd, input bit last,
                      input logic [7:0] h, input bit early);
    @(negedge clk);
    if (early) begin
      in_data = d; in_is_data = isd; in_last = last; half_period = h; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
    end else begin
      while (!in_ready) @(negedge clk);
      in_data = d; in_is_data = isd; in_last = last; half_period = h; in_valid = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    #2;
  endtask

  // {data[7:0], is_data, last, half[3:0]}
  localparam logic [13:0] VEC [8] = '{
    {8'hA5, 1'b0, 1'b1, 4'd1},
    {8'h3C, 1'b1, 1'b1, 4'd2},
    {8'h00, 1'b0, 1'b0, 4'd0},
    {8'hFF, 1'b1, 1'b1, 4'd3},
    {8'h81, 1'b0, 1'b1, 4'd4},
    {8'h7E, 1'b1, 1'b1, 4'd1},
    {8'hC3, 1'b0, 1'b0, 4'd2},
    {8'h5A, 1'b1, 1'b1, 4'd5}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int r0, r1, rr, bc, us, cr, hh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(disp_csn && disp_rs && disp_sck && disp_sda, "R1 lines high", {disp_csn, disp_rs, disp_sck, disp_sda}, 15);
    chk(!busy && in_ready, "R1 busy low, ready high", {busy, in_ready}, 1);

    // Vector walk: single-byte transactions
    for (int i = 0; i < 8; i++) begin
      r0 = rs0_at8; r1 = rs1_at8; rr = rises; bc = busy_cyc; us = unstable;
      hh = (VEC[i][3:0] == 0) ? 1 : int'(VEC[i][3:0]);
      send(VEC[i][13:6], VEC[i][5], VEC[i][4], {4'd0, VEC[i][3:0]}, 1'b0);
      wait_idle();
      chk(cap[7:0] == VEC[i][13:6], "R4 byte MSB first", int'(cap[7:0]), int'(VEC[i][13:6]));
      chk(rises - rr == 8, "R4 eight rises", rises - rr, 8);
      chk(unstable == us, "R4 data stable at rise", unstable - us, 0);
      if (VEC[i][5]) chk(rs1_at8 - r1 == 1 && rs0_at8 == r0, "R3 rs high at 8th rise", rs1_at8 - r1, 1);
      else           chk(rs0_at8 - r0 == 1 && rs1_at8 == r1, "R2 rs low at 8th rise", rs0_at8 - r0, 1);
      chk(busy_cyc - bc == 17 * hh, "R6 phase timing", busy_cyc - bc, 17 * hh);
      chk(disp_csn && disp_rs && disp_sck && disp_sda && !busy, "R8 lines high at end",
          {disp_csn, disp_rs, disp_sck, disp_sda}, 15);
    end

    // R5 start phase and R7 ready low while shifting
    send(8'h96, 1'b0, 1'b1, 8'd3, 1'b0);
    chk(!disp_csn && !disp_sck && disp_sda, "R5 setup lines", {disp_csn, disp_sck, disp_sda}, 1);
    chk(busy, "R9 busy with csn low", busy, 1);
    repeat (6) @(negedge clk);
    chk(!in_ready, "R7 ready low mid-byte", in_ready, 0);
    wait_idle();
    chk(cap[7:0] == 8'h96, "R5 byte after setup", int'(cap[7:0]), 8'h96);

    // R6 divider captured at start: change mid-transaction
    bc = busy_cyc;
    send(8'h42, 1'b1, 1'b1, 8'd2, 1'b0);
    half_period = 8'd5;
    wait_idle();
    chk(busy_cyc - bc == 34, "R6 divider latched", busy_cyc - bc, 34);

    // R3/R7/R10 burst with stall and a command flag on a later byte
    r0 = rs0_at8; r1 = rs1_at8; rr = rises; cr = csn_rises;
    send(8'h12, 1'b1, 1'b0, 8'd1, 1'b0);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(in_ready && disp_sck && !disp_csn, "R7 wait holds clock high",
        {in_ready, disp_sck, disp_csn}, 6);
    send(8'h34, 1'b0, 1'b0, 8'd4, 1'b0);
    send(8'h56, 1'b1, 1'b1, 8'd4, 1'b0);
    wait_idle();
    chk(cap[23:0] == 24'h123456, "R3 burst bytes", int'(cap[23:0]), 24'h123456);
    chk(csn_rises - cr == 1, "R3 csn held across burst", csn_rises - cr, 1);
    chk(rs1_at8 - r1 == 3 && rs0_at8 == r0, "R10 later flag ignored", rs0_at8 - r0, 0);
    chk(rises - rr == 24, "R3 24 rises", rises - rr, 24);

    // End of one transaction meets a waiting request for the next
    cr = csn_rises;
    send(8'hE7, 1'b0, 1'b1, 8'd2, 1'b0);
    send(8'h18, 1'b0, 1'b0, 8'd1, 1'b1);
    wait_idle();
    chk(cap[15:0] == 16'hE718, "R2 back-to-back commands", int'(cap[15:0]), 16'hE718);
    chk(csn_rises - cr == 2, "R2 one byte per command", csn_rises - cr, 2);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule